// File: doc/BRIEF.md
# Exception Entry Controller

This block decides how a 32-bit core with banked processor modes enters an exception. Each cycle it looks at seven request lines: reset, undefined instruction, supervisor call, prefetch abort, data abort, normal interrupt and fast interrupt. It also looks at the current status word, the return address derived from the program counter, and a high-vectors select. When at least one request may be taken, it picks the most urgent one and produces the four entry values. These are the status word for the handler, the value to bank into the target mode's saved status register, the value to bank into that mode's link register, and the vector fetch address. The core uses these four values in one step.

The control is a two-state machine. In `ST_RUN` the block watches the requests. The transition `accept` moves it to `ST_ENTER` when an eligible request is present, and `idle` keeps it in `ST_RUN` when there is none. `ST_ENTER` lasts exactly one cycle. In that cycle `take_exc` is high, the registered entry values and the write enables are valid, and all requests are ignored. The transition `retire` then always returns the machine to `ST_RUN`. Exception codes equal the vector offset divided by four, so code and vector address agree by construction of the encoding.

Top module: `exc_entry_ctrl`

## Requirements
- R1: `take_exc` rises one clock after an eligible request is presented in `ST_RUN` and stays high for exactly one cycle. `exc_code` then identifies the exception: 0 reset, 1 undefined, 2 supervisor call, 3 prefetch abort, 4 data abort, 6 normal interrupt, 7 fast interrupt.
- R2: With several eligible requests, exactly one is taken, in this order from highest to lowest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, supervisor call.
- R3: A normal interrupt request is eligible only when status bit 7 is 0. A fast interrupt request is eligible only when status bit 6 is 0. If no request is eligible, `take_exc` stays low.
- R4: `new_status[4:0]` holds the target mode: 10011 for reset and supervisor call, 11011 for undefined, 10111 for both aborts, 10010 for normal interrupt, 10001 for fast interrupt.
- R5: `new_status` sets bit 7 for every exception. It sets bit 8 for reset, both aborts and fast interrupt. It sets bit 6 for reset and fast interrupt. It clears bit 5. Bits 31:9 and any mask bit not named here are copied from the current status word.
- R6: `vec_addr` equals the base plus four times `exc_code`. The base is 0x00000000 when `hivec` was 0 and 0xFFFF0000 when it was 1.
- R7: For every exception except reset, `spsr_wr_en` and `lr_wr_en` are high during `take_exc`. `spsr_val` then equals the status word and `lr_val` the return address presented with the request. Reset raises neither enable.
- R8: Requests still present during the `ST_ENTER` cycle are ignored. The cycle after `take_exc` has `take_exc` low.
- R9: While `rst_n` is low, and while `take_exc` is low, both write enables are low. After reset `take_exc` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_svc | input | 1 | Supervisor call request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| cur_status | input | 32 | Current status word |
| ret_addr | input | 32 | Return address for the link register |
| hivec | input | 1 | High vector base select |
| take_exc | output | 1 | One-cycle exception entry pulse |
| exc_code | output | 3 | Code of the taken exception |
| new_status | output | 32 | Status word for the handler |
| spsr_wr_en | output | 1 | Write enable for the saved status register |
| spsr_val | output | 32 | Value for the saved status register |
| lr_wr_en | output | 1 | Write enable for the banked link register |
| lr_val | output | 32 | Value for the banked link register |
| vec_addr | output | 32 | Vector fetch address |

## Verification
The properties assume that the status word, return address and `hivec` presented with a request are the values the core holds at that edge. They compare entry outputs against those inputs one cycle earlier, and they assume requests are plain levels with no meaning during the entry cycle. The stimulus sweeps every combination of the seven request lines, both interrupt mask bits and both vector bases. It changes inputs only at falling edges and holds them steady across the accepting edge. It keeps requests held through the entry cycle and releases them only afterwards, so the retire path is exercised without starting an unintended second entry.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int unsigned STATUS_W = 32;
    localparam int unsigned MODE_W   = 5;
    localparam int unsigned NUM_SRC  = 7;
    localparam int unsigned CODE_W   = 3;

    // status word bit positions
    localparam int unsigned SB_A = 8;
    localparam int unsigned SB_I = 7;
    localparam int unsigned SB_F = 6;
    localparam int unsigned SB_T = 5;

    // mode encodings
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;

    // exception codes: vector offset divided by four
    typedef enum logic [CODE_W-1:0] {
        EXC_RESET = 3'd0,
        EXC_UNDEF = 3'd1,
        EXC_SVC   = 3'd2,
        EXC_PABT  = 3'd3,
        EXC_DABT  = 3'd4,
        EXC_IRQ   = 3'd6,
        EXC_FIQ   = 3'd7
    } exc_code_t;

    // priority slots, 0 is the most urgent
    localparam int unsigned SLOT_RESET = 0;
    localparam int unsigned SLOT_DABT  = 1;
    localparam int unsigned SLOT_FIQ   = 2;
    localparam int unsigned SLOT_IRQ   = 3;
    localparam int unsigned SLOT_PABT  = 4;
    localparam int unsigned SLOT_UNDEF = 5;
    localparam int unsigned SLOT_SVC   = 6;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              set_a;
        logic              set_f;
    } exc_profile_t;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ENTER = 1'b1
    } entry_state_t;

    function automatic exc_code_t slot_code(input int unsigned slot);
        case (slot)
            SLOT_RESET: return EXC_RESET;
            SLOT_DABT:  return EXC_DABT;
            SLOT_FIQ:   return EXC_FIQ;
            SLOT_IRQ:   return EXC_IRQ;
            SLOT_PABT:  return EXC_PABT;
            SLOT_UNDEF: return EXC_UNDEF;
            default:    return EXC_SVC;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic [N-1:0] req_prio,
    input  logic         irq_mask,
    input  logic         fiq_mask,
    output logic         grant_vld,
    output exc_code_t    grant_code
);

    logic [N-1:0] elig;
    logic [N-1:0] grant;

    // per-slot gating by the interrupt masks
    for (genvar i = 0; i < N; i++) begin : g_elig
        if (i == SLOT_IRQ) begin : g_irq
            assign elig[i] = req_prio[i] & ~irq_mask;
        end else if (i == SLOT_FIQ) begin : g_fiq
            assign elig[i] = req_prio[i] & ~fiq_mask;
        end else begin : g_plain
            assign elig[i] = req_prio[i];
        end
    end

    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            grant[i] = elig[i] & ~seen;
            seen     = seen | elig[i];
        end
    end

    always_comb begin
        grant_code = EXC_RESET;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) grant_code = slot_code(i);
        end
    end

    assign grant_vld = |elig;

endmodule

// File: rtl/exc_profile.sv
module exc_profile
    import exc_pkg::*;
(
    input  exc_code_t    code,
    output exc_profile_t prof
);

    always_comb begin
        unique case (code)
            EXC_RESET: prof = '{mode: MODE_SVC, set_a: 1'b1, set_f: 1'b1};
            EXC_UNDEF: prof = '{mode: MODE_UND, set_a: 1'b0, set_f: 1'b0};
            EXC_SVC:   prof = '{mode: MODE_SVC, set_a: 1'b0, set_f: 1'b0};
            EXC_PABT:  prof = '{mode: MODE_ABT, set_a: 1'b1, set_f: 1'b0};
            EXC_DABT:  prof = '{mode: MODE_ABT, set_a: 1'b1, set_f: 1'b0};
            EXC_IRQ:   prof = '{mode: MODE_IRQ, set_a: 1'b0, set_f: 1'b0};
            EXC_FIQ:   prof = '{mode: MODE_FIQ, set_a: 1'b1, set_f: 1'b1};
            default:   prof = '{mode: MODE_SVC, set_a: 1'b0, set_f: 1'b0};
        endcase
    end

endmodule

// File: rtl/exc_status_build.sv
module exc_status_build
    import exc_pkg::*;
(
    input  logic [STATUS_W-1:0] old_status,
    input  exc_profile_t        prof,
    output logic [STATUS_W-1:0] entry_status
);

    always_comb begin
        entry_status              = old_status;
        entry_status[MODE_W-1:0]  = prof.mode;
        entry_status[SB_I]        = 1'b1;
        entry_status[SB_T]        = 1'b0;
        if (prof.set_a) entry_status[SB_A] = 1'b1;
        if (prof.set_f) entry_status[SB_F] = 1'b1;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int unsigned      ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] LO_VEC_BASE = '0,
    parameter logic [ADDR_W-1:0] HI_VEC_BASE = 32'hFFFF_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_reset,
    input  logic                req_undef,
    input  logic                req_svc,
    input  logic                req_pabt,
    input  logic                req_dabt,
    input  logic                req_irq,
    input  logic                req_fiq,
    input  logic [STATUS_W-1:0] cur_status,
    input  logic [ADDR_W-1:0]   ret_addr,
    input  logic                hivec,
    output logic                take_exc,
    output logic [CODE_W-1:0]   exc_code,
    output logic [STATUS_W-1:0] new_status,
    output logic                spsr_wr_en,
    output logic [STATUS_W-1:0] spsr_val,
    output logic                lr_wr_en,
    output logic [ADDR_W-1:0]   lr_val,
    output logic [ADDR_W-1:0]   vec_addr
);

    localparam int unsigned OFS_PAD = ADDR_W - CODE_W - 2;

    entry_state_t        state_q, state_d;
    logic [NUM_SRC-1:0]  req_prio;
    logic                sel_vld;
    exc_code_t           sel_code;
    exc_profile_t        sel_prof;
    logic [STATUS_W-1:0] sel_status;
    logic [ADDR_W-1:0]   sel_vec;
    logic                accept;

    logic [CODE_W-1:0]   code_q;
    logic [STATUS_W-1:0] status_q;
    logic [STATUS_W-1:0] spsr_q;
    logic [ADDR_W-1:0]   lr_q;
    logic [ADDR_W-1:0]   vec_q;
    logic                bank_we_q;

    // slot order follows the priority slots of the package
    assign req_prio = {req_svc, req_undef, req_pabt, req_irq,
                       req_fiq, req_dabt, req_reset};

    exc_arbiter #(.N(NUM_SRC)) u_arb (
        .req_prio   (req_prio),
        .irq_mask   (cur_status[SB_I]),
        .fiq_mask   (cur_status[SB_F]),
        .grant_vld  (sel_vld),
        .grant_code (sel_code)
    );

    exc_profile u_prof (
        .code (sel_code),
        .prof (sel_prof)
    );

    exc_status_build u_stat (
        .old_status   (cur_status),
        .prof         (sel_prof),
        .entry_status (sel_status)
    );

    assign sel_vec = (hivec ? HI_VEC_BASE : LO_VEC_BASE)
                   + {{OFS_PAD{1'b0}}, sel_code, 2'b00};

    // next state: accept / idle / retire
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (sel_vld) begin
                    state_d = ST_ENTER;
                    accept  = 1'b1;
                end
            end
            ST_ENTER: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // entry value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q    <= '0;
            status_q  <= '0;
            spsr_q    <= '0;
            lr_q      <= '0;
            vec_q     <= '0;
            bank_we_q <= 1'b0;
        end else begin
            bank_we_q <= 1'b0;
            if (accept) begin
                code_q    <= sel_code;
                status_q  <= sel_status;
                spsr_q    <= cur_status;
                lr_q      <= ret_addr;
                vec_q     <= sel_vec;
                bank_we_q <= (sel_code != EXC_RESET);
            end
        end
    end

    assign take_exc   = (state_q == ST_ENTER);
    assign exc_code   = code_q;
    assign new_status = status_q;
    assign spsr_val   = spsr_q;
    assign lr_val     = lr_q;
    assign vec_addr   = vec_q;
    assign spsr_wr_en = bank_we_q;
    assign lr_wr_en   = bank_we_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int unsigned      ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] LO_VEC_BASE = '0,
    parameter logic [ADDR_W-1:0] HI_VEC_BASE = 32'hFFFF_0000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_reset,
    input logic                req_undef,
    input logic                req_svc,
    input logic                req_pabt,
    input logic                req_dabt,
    input logic                req_irq,
    input logic                req_fiq,
    input logic [STATUS_W-1:0] cur_status,
    input logic [ADDR_W-1:0]   ret_addr,
    input logic                hivec,
    input logic                take_exc,
    input logic [CODE_W-1:0]   exc_code,
    input logic [STATUS_W-1:0] new_status,
    input logic                spsr_wr_en,
    input logic [STATUS_W-1:0] spsr_val,
    input logic                lr_wr_en,
    input logic [ADDR_W-1:0]   lr_val,
    input logic [ADDR_W-1:0]   vec_addr
);

    localparam int unsigned OFS_PAD = ADDR_W - CODE_W - 2;

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |=> !take_exc);

    a_r2_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && $past(req_reset)) |-> exc_code == 3'd0);

    a_r2_dabt_over_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && $past(req_dabt) && !$past(req_reset)) |-> exc_code == 3'd4);

    a_r3_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_code == 3'd6) |-> !$past(cur_status[SB_I]));

    a_r3_fiq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_code == 3'd7) |-> !$past(cur_status[SB_F]));

    a_r4_fiq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_code == 3'd7) |-> new_status[MODE_W-1:0] == MODE_FIQ);

    a_r5_masks: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> (new_status[SB_I] && !new_status[SB_T]
                      && new_status[STATUS_W-1:9] == $past(cur_status[STATUS_W-1:9])));

    a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> vec_addr == (($past(hivec) ? HI_VEC_BASE : LO_VEC_BASE)
                                  + {{OFS_PAD{1'b0}}, exc_code, 2'b00}));

    a_r7_banked_values: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_code != 3'd0) |->
            (spsr_wr_en && lr_wr_en && spsr_val == $past(cur_status)
             && lr_val == $past(ret_addr)));

    a_r7_reset_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_code == 3'd0) |-> (!spsr_wr_en && !lr_wr_en));

    a_r8_ignore_in_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && ($past(req_reset) || req_reset)) |=> !take_exc);

    a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !take_exc |-> (!spsr_wr_en && !lr_wr_en));

    // inputs only consulted through $past above or not at all
    logic unused_ok;
    assign unused_ok = ^{req_undef, req_svc, req_pabt, req_irq, req_fiq};

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .ADDR_W      (ADDR_W),
    .LO_VEC_BASE (LO_VEC_BASE),
    .HI_VEC_BASE (HI_VEC_BASE)
) u_entry_chk (.*);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_reset = 0, req_undef = 0, req_svc = 0, req_pabt = 0;
    logic        req_dabt = 0, req_irq = 0, req_fiq = 0;
    logic [31:0] cur_status = '0;
    logic [31:0] ret_addr = '0;
    logic        hivec = 1'b0;
    logic        take_exc;
    logic [2:0]  exc_code;
    logic [31:0] new_status;
    logic        spsr_wr_en;
    logic [31:0] spsr_val;
    logic        lr_wr_en;
    logic [31:0] lr_val;
    logic [31:0] vec_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_reset(req_reset), .req_undef(req_undef), .req_svc(req_svc),
        .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq),
        .req_fiq(req_fiq), .cur_status(cur_status), .ret_addr(ret_addr),
        .hivec(hivec), .take_exc(take_exc), .exc_code(exc_code),
        .new_status(new_status), .spsr_wr_en(spsr_wr_en), .spsr_val(spsr_val),
        .lr_wr_en(lr_wr_en), .lr_val(lr_val), .vec_addr(vec_addr)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // request bit map: 0 reset,1 undef,2 svc,3 pabt,4 dabt,5 irq,6 fiq
    function automatic int pick(input logic [6:0] r, input bit im, input bit fm);
        if (r[0])        return 0;
        if (r[4])        return 4;
        if (r[6] && !fm) return 7;
        if (r[5] && !im) return 6;
        if (r[3])        return 3;
        if (r[1])        return 1;
        if (r[2])        return 2;
        return -1;
    endfunction

    function automatic logic [4:0] mode_of(input int c);
        case (c)
            0, 2:    return 5'b10011;
            1:       return 5'b11011;
            3, 4:    return 5'b10111;
            6:       return 5'b10010;
            default: return 5'b10001;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(take_exc == 1'b0, "R9 take low in reset", {31'd0, take_exc}, 32'd0);
        chk(!spsr_wr_en && !lr_wr_en, "R9 enables low in reset",
            {30'd0, spsr_wr_en, lr_wr_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(take_exc == 1'b0, "R9 take low after reset", {31'd0, take_exc}, 32'd0);

        for (int pat = 0; pat < 128; pat++) begin
            for (int msk = 0; msk < 4; msk++) begin
                for (int hv = 0; hv < 2; hv++) begin
                    logic [6:0]  r;
                    logic [31:0] st, ra, exp_st, exp_vec;
                    int          c;
                    r  = pat[6:0];
                    st = 32'hC3A5_0F00 ^ (pat * 32'h0101_0103) ^ (hv << 9);
                    st[7]   = msk[0];
                    st[6]   = msk[1];
                    st[5]   = pat[0];
                    st[4:0] = 5'b10000;
                    ra = 32'h0000_8000 + pat * 16 + msk * 4 + hv;
                    c  = pick(r, msk[0], msk[1]);

                    {req_fiq, req_irq, req_dabt, req_pabt, req_svc, req_undef, req_reset} = r;
                    cur_status = st;
                    ret_addr   = ra;
                    hivec      = hv[0];
                    @(posedge clk);
                    @(negedge clk);

                    if (c < 0) begin
                        chk(take_exc == 1'b0, "R3 no eligible request, no take",
                            {31'd0, take_exc}, 32'd0);
                    end else begin
                        exp_st = st;
                        exp_st[4:0] = mode_of(c);
                        exp_st[7] = 1'b1;
                        exp_st[5] = 1'b0;
                        if (c == 0 || c == 3 || c == 4 || c == 7) exp_st[8] = 1'b1;
                        if (c == 0 || c == 7) exp_st[6] = 1'b1;
                        exp_vec = (hv != 0 ? 32'hFFFF_0000 : 32'h0) + c * 4;
                        chk(take_exc == 1'b1, "R1 take pulse", {31'd0, take_exc}, 32'd1);
                        chk(exc_code == c[2:0], "R2 priority code", {29'd0, exc_code}, c);
                        chk(new_status[4:0] == exp_st[4:0], "R4 target mode",
                            new_status, exp_st);
                        chk(new_status == exp_st, "R5 status bits", new_status, exp_st);
                        chk(vec_addr == exp_vec, "R6 vector", vec_addr, exp_vec);
                        if (c == 0) begin
                            chk(!spsr_wr_en && !lr_wr_en, "R7 reset banks nothing",
                                {30'd0, spsr_wr_en, lr_wr_en}, 32'd0);
                        end else begin
                            chk(spsr_wr_en && lr_wr_en, "R7 bank enables",
                                {30'd0, spsr_wr_en, lr_wr_en}, 32'd3);
                            chk(spsr_val == st, "R7 saved status", spsr_val, st);
                            chk(lr_val == ra, "R7 link value", lr_val, ra);
                        end
                    end

                    @(posedge clk);
                    @(negedge clk);
                    chk(take_exc == 1'b0, "R8 requests ignored in entry cycle",
                        {31'd0, take_exc}, 32'd0);
                    chk(!spsr_wr_en && !lr_wr_en, "R9 enables low without take",
                        {30'd0, spsr_wr_en, lr_wr_en}, 32'd0);
                    {req_fiq, req_irq, req_dabt, req_pabt, req_svc, req_undef, req_reset} = '0;
                    @(posedge clk);
                    @(negedge clk);
                end
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule